// File: doc/BRIEF.md
# Column Command Spacing Checker

This block sits beside a memory controller's command scheduler and keeps data bursts on the shared data bus of one rank from overlapping. It remembers the kind of the most recent column command (read or write, with or without auto-precharge) and how many clocks have passed since it issued. Each cycle the scheduler may present a candidate command. One cycle later the block reports whether that candidate could have issued and how many more clocks it would have had to wait.

The history is a small state machine with three states. ST_EMPTY means no column command has issued since reset. ST_AFTER_RD means the last column command was a read. ST_AFTER_WR means it was a write. The transitions are these. Issue-read moves any state to ST_AFTER_RD. Issue-write moves any state to ST_AFTER_WR. Hold keeps the current state: it applies when nothing issues or when a non-column command issues. Reset returns to ST_EMPTY. An elapsed-cycle counter restarts at 1 on every column issue and counts up, saturating at the largest gap.

The required gap depends on the last command and the candidate. Two commands of the same direction are separated by the larger of the column-to-column delay and the burst length. A write followed by a read waits for the write latency, then the burst, then the write-to-read recovery. A read followed by a write waits for the read latency plus the burst, minus the write latency, plus two clocks of bus turnaround.

Top module: `colspc_chk`

## Requirements
- R1: Read after read, or write after write, needs a gap of max(T_CCD, BURST) clocks. With the default parameters this is 4.
- R2: Read after write needs a gap of T_WL + BURST + T_WTR clocks. With the default parameters this is 13.
- R3: Write after read needs a gap of T_RL + BURST − T_WL + 2 clocks. With the default parameters this is 7.
- R4: Command codes are 1 = read, 2 = read with auto-precharge, 3 = write and 4 = write with auto-precharge. The auto-precharge codes are spaced exactly like the plain read (1) and the plain write (3), both as a candidate and as history.
- R5: When no column command has issued since reset, any column candidate gets cand_ok=1 and cand_wait=0.
- R6: A valid candidate whose code is not a column code (0, 5, 6 or 7) gives cand_err=1, cand_ok=0 and cand_wait=0.
- R7: The outputs are registered. They reflect the candidate sampled at the previous rising edge. Distance d is the number of edges since the column command issued, so d=1 in the cycle right after the issue. The block reports cand_wait = max(0, gap − d), and cand_ok=1 exactly when the candidate is a valid column code and cand_wait is 0. When cand_valid is low, all outputs are 0.
- R8: An issue with iss_valid low, or with a non-column code, leaves the history unchanged.
- R9: A candidate presented in the same cycle as an issue is judged against the history from before that issue.
- R10: During reset and right after it, cand_ok, cand_err and cand_wait are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_valid | input | 1 | A candidate is presented this cycle |
| cand_cmd | input | 3 | Candidate command code |
| iss_valid | input | 1 | A command issues this cycle |
| iss_cmd | input | 3 | Code of the issuing command |
| cand_ok | output | 1 | The previous cycle's candidate was allowed |
| cand_err | output | 1 | The previous cycle's candidate was not a column command |
| cand_wait | output | CNT_W | Remaining clocks for the previous cycle's candidate |

## Verification
Some properties are checked by the assertions on every cycle:
- cand_err and cand_ok are never both set, and an error always carries a zero wait.
- A column issue restarts the elapsed count at 1.
- The count holds once it saturates.
- A non-column issue or an idle cycle does not change the history state.
- An empty history never produces a wait.

The actual gap values for each pairing can only be shown by the bench scenarios. These include the auto-precharge variants, same-cycle candidate and issue, and the one-cycle output latency. The bench's reference model tracks the last column command and its cycle number, and compares all three outputs on every clock.

// File: rtl/colspc_pkg.sv
package colspc_pkg;

    typedef enum logic [2:0] {
        CMD_NOP  = 3'd0,
        CMD_RD   = 3'd1,
        CMD_RDAP = 3'd2,
        CMD_WR   = 3'd3,
        CMD_WRAP = 3'd4,
        CMD_ACT  = 3'd5,
        CMD_PRE  = 3'd6,
        CMD_REF  = 3'd7
    } cmd_e;

    typedef enum logic [1:0] {
        ST_EMPTY    = 2'd0,
        ST_AFTER_RD = 2'd1,
        ST_AFTER_WR = 2'd2
    } hist_e;

    function automatic logic is_col(input logic [2:0] c);
        return (c == CMD_RD) || (c == CMD_RDAP) || (c == CMD_WR) || (c == CMD_WRAP);
    endfunction

    function automatic logic is_read(input logic [2:0] c);
        return (c == CMD_RD) || (c == CMD_RDAP);
    endfunction

endpackage

// File: rtl/colspc_hist.sv
module colspc_hist
    import colspc_pkg::*;
#(
    parameter int CNT_W   = 4,
    parameter int CNT_MAX = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iss_valid,
    input  logic [2:0]       iss_cmd,
    output hist_e            state,
    output logic [CNT_W-1:0] elapsed
);

    localparam logic [CNT_W-1:0] SAT = CNT_W'(CNT_MAX);

    hist_e state_nx;
    logic  col_issue;

    assign col_issue = iss_valid && is_col(iss_cmd);

    // next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY, ST_AFTER_RD, ST_AFTER_WR: begin
                if (col_issue) begin
                    state_nx = is_read(iss_cmd) ? ST_AFTER_RD : ST_AFTER_WR;
                end
            end
            default: state_nx = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nx;
        end
    end

    // elapsed-cycle counter, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            elapsed <= '0;
        end else if (col_issue) begin
            elapsed <= CNT_W'(1);
        end else if (state != ST_EMPTY && elapsed != SAT) begin
            elapsed <= elapsed + CNT_W'(1);
        end
    end

    a_r7_restart: assert property (@(posedge clk) disable iff (!rst_n)
        col_issue |=> (elapsed == CNT_W'(1)));

    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (elapsed == SAT && !col_issue) |=> (elapsed == SAT));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !col_issue |=> $stable(state));

endmodule

// File: rtl/colspc_gap.sv
module colspc_gap
    import colspc_pkg::*;
#(
    parameter int CNT_W    = 4,
    parameter int GAP_SAME = 4,
    parameter int GAP_W2R  = 13,
    parameter int GAP_R2W  = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  hist_e            state,
    input  logic [2:0]       cand_cmd,
    input  logic [CNT_W-1:0] elapsed,
    output logic [CNT_W-1:0] remain
);

    localparam logic [CNT_W-1:0] G_SAME = CNT_W'(GAP_SAME);
    localparam logic [CNT_W-1:0] G_W2R  = CNT_W'(GAP_W2R);
    localparam logic [CNT_W-1:0] G_R2W  = CNT_W'(GAP_R2W);

    logic [CNT_W-1:0] gap;
    logic             rd_cand;

    assign rd_cand = is_read(cand_cmd);

    always_comb begin
        gap = '0;
        unique case (state)
            ST_EMPTY:    gap = '0;
            ST_AFTER_RD: gap = rd_cand ? G_SAME : G_R2W;
            ST_AFTER_WR: gap = rd_cand ? G_W2R  : G_SAME;
            default:     gap = '0;
        endcase
        remain = (elapsed >= gap) ? '0 : (gap - elapsed);
    end

    a_r5_empty_free: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (remain == '0));

endmodule

// File: rtl/colspc_chk.sv
module colspc_chk
    import colspc_pkg::*;
#(
    parameter int BURST = 4,
    parameter int T_CCD = 4,
    parameter int T_WL  = 5,
    parameter int T_RL  = 6,
    parameter int T_WTR = 4,
    localparam int GAP_SAME = (T_CCD > BURST) ? T_CCD : BURST,
    localparam int GAP_W2R  = T_WL + BURST + T_WTR,
    localparam int GAP_R2W  = T_RL + BURST - T_WL + 2,
    localparam int GAP_MAX0 = (GAP_SAME > GAP_W2R) ? GAP_SAME : GAP_W2R,
    localparam int GAP_MAX  = (GAP_MAX0 > GAP_R2W) ? GAP_MAX0 : GAP_R2W,
    localparam int CNT_W    = $clog2(GAP_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cand_valid,
    input  logic [2:0]       cand_cmd,
    input  logic             iss_valid,
    input  logic [2:0]       iss_cmd,
    output logic             cand_ok,
    output logic             cand_err,
    output logic [CNT_W-1:0] cand_wait
);

    hist_e            state;
    logic [CNT_W-1:0] elapsed;
    logic [CNT_W-1:0] remain;
    logic             cand_col;

    colspc_hist #(.CNT_W(CNT_W), .CNT_MAX(GAP_MAX)) u_hist (
        .clk       (clk),
        .rst_n     (rst_n),
        .iss_valid (iss_valid),
        .iss_cmd   (iss_cmd),
        .state     (state),
        .elapsed   (elapsed)
    );

    colspc_gap #(
        .CNT_W    (CNT_W),
        .GAP_SAME (GAP_SAME),
        .GAP_W2R  (GAP_W2R),
        .GAP_R2W  (GAP_R2W)
    ) u_gap (
        .clk      (clk),
        .rst_n    (rst_n),
        .state    (state),
        .cand_cmd (cand_cmd),
        .elapsed  (elapsed),
        .remain   (remain)
    );

    assign cand_col = cand_valid && is_col(cand_cmd);

    // registered verdict, one cycle after the candidate
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_ok   <= 1'b0;
            cand_err  <= 1'b0;
            cand_wait <= '0;
        end else begin
            cand_err  <= cand_valid && !is_col(cand_cmd);
            cand_ok   <= cand_col && (remain == '0);
            cand_wait <= cand_col ? remain : '0;
        end
    end

    a_r6_err_excl: assert property (@(posedge clk) disable iff (!rst_n)
        cand_err |-> (!cand_ok && cand_wait == '0));

    a_r7_ok_nowait: assert property (@(posedge clk) disable iff (!rst_n)
        cand_ok |-> (cand_wait == '0));

    a_r7_wait_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cand_wait <= CNT_W'(GAP_MAX));

endmodule

// File: tb/colspc_chk_tb.sv
module colspc_chk_tb;

    localparam int CLK_PERIOD = 10;
    // gaps derived from the requirements with default parameters
    localparam int G_SAME = 4;   // R1: max(4,4)
    localparam int G_W2R  = 13;  // R2: 5+4+4
    localparam int G_R2W  = 7;   // R3: 6+4-5+2

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cand_valid = 1'b0;
    logic [2:0] cand_cmd = 3'd0;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_cmd = 3'd0;
    logic       cand_ok;
    logic       cand_err;
    logic [3:0] cand_wait;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int cyc = 0;
    int last_t = -1;      // -1 none, 0 read, 1 write
    int last_cyc = 0;
    bit done = 1'b0;

    colspc_chk u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand_valid (cand_valid),
        .cand_cmd   (cand_cmd),
        .iss_valid  (iss_valid),
        .iss_cmd    (iss_cmd),
        .cand_ok    (cand_ok),
        .cand_err   (cand_err),
        .cand_wait  (cand_wait)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 200000 && !done) begin
            errors = errors + 1;
            $display("FAIL R7 watchdog actual=hang expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic bit m_col(input logic [2:0] c);
        return c >= 3'd1 && c <= 3'd4;
    endfunction

    function automatic bit m_rd(input logic [2:0] c);
        return c == 3'd1 || c == 3'd2;
    endfunction

    task automatic compare(input string tag, input bit eo, input bit ee, input int ew);
        checks++;
        if (cand_ok !== eo || cand_err !== ee || int'(cand_wait) != ew) begin
            errors++;
            $display("FAIL %s ok=%0d err=%0d wait=%0d expected ok=%0d err=%0d wait=%0d",
                     tag, cand_ok, cand_err, cand_wait, eo, ee, ew);
        end
    endtask

    // called just after a falling edge
    task automatic step(input bit cv, input logic [2:0] cc, input bit iv,
                        input logic [2:0] ic, input string force_tag);
        bit eo; bit ee; int ew; int gap; int d; string tag;
        cand_valid = cv; cand_cmd = cc; iss_valid = iv; iss_cmd = ic;
        eo = 0; ee = 0; ew = 0; tag = "R7";
        if (cv && !m_col(cc)) begin
            ee = 1; tag = "R6";
        end else if (cv) begin
            if (last_t < 0) begin
                gap = 0; tag = "R5";
            end else if (last_t == 0) begin
                gap = m_rd(cc) ? G_SAME : G_R2W; tag = m_rd(cc) ? "R1" : "R3";
            end else begin
                gap = m_rd(cc) ? G_W2R : G_SAME; tag = m_rd(cc) ? "R2" : "R1";
            end
            if (last_t >= 0 && (cc == 3'd2 || cc == 3'd4)) tag = "R4";
            d = cyc - last_cyc;
            ew = (gap > d) ? gap - d : 0;
            eo = (ew == 0);
        end
        if (force_tag != "") tag = force_tag;
        if (iv && m_col(ic)) begin
            last_t = m_rd(ic) ? 0 : 1;
            last_cyc = cyc;
        end
        @(posedge clk);
        cyc++;
        @(negedge clk);
        compare(tag, eo, ee, ew);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare("R10", 0, 0, 0);           // R10 during reset
        rst_n = 1'b1;
        @(posedge clk); cyc++;
        @(negedge clk);
        compare("R10", 0, 0, 0);           // R10 after release
        step(1, 3'd3, 0, 3'd0, "R5");      // R5 write with empty history
        step(1, 3'd1, 1, 3'd1, "R9");      // R9 same-cycle issue: still empty
        for (int i = 0; i < 5; i++) step(1, 3'd1, 0, 3'd0, "R1");  // R1 countdown
        step(1, 3'd3, 1, 3'd3, "");        // R3 then issue write
        for (int i = 0; i < 14; i++) step(1, 3'd1, 0, 3'd0, "R2");  // R2 countdown
        step(1, 3'd2, 1, 3'd4, "R4");      // R4 write-with-precharge history
        for (int i = 0; i < 14; i++) step(1, 3'd2, 0, 3'd0, "R4");
        step(1, 3'd4, 1, 3'd2, "");
        for (int i = 0; i < 8; i++) step(1, 3'd4, 0, 3'd0, "R4");   // R4 read-AP to write-AP
        step(1, 3'd5, 0, 3'd0, "R6");      // R6 activate as candidate
        step(1, 3'd0, 0, 3'd0, "R6");
        step(1, 3'd7, 0, 3'd0, "R6");
        step(1, 3'd1, 1, 3'd1, "");
        step(1, 3'd3, 1, 3'd6, "R8");      // R8 precharge issue ignored
        step(1, 3'd3, 1, 3'd5, "R8");
        step(1, 3'd3, 0, 3'd3, "R8");      // R8 iss_valid low
        step(1, 3'd3, 0, 3'd0, "R8");
        step(0, 3'd1, 0, 3'd0, "R7");      // R7 no candidate
        for (int i = 0; i < 3000; i++) begin
            step($urandom_range(0, 7) != 0, 3'($urandom_range(0, 7)),
                 $urandom_range(0, 5) == 0, 3'($urandom_range(0, 7)), "");
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule